// File: doc/BRIEF.md
# Serial-Loaded Memory Bank Controller

This block maps the program and pattern ROM of a cartridge into fixed windows of the console's address space. Software programs it by writing to any address in the upper 32 KB of CPU space. Each write carries one bit, and five such writes make up one 5-bit value. An internal marker bit shows when the fifth bit has arrived. That write then commits the value to one of four internal registers, chosen by address bits 14:13 of that final write. The registers are control, pattern bank 0, pattern bank 1 and program bank.

A write with data bit 7 set aborts a partial load at any time. It also forces the program layout back to the mode that fixes the last bank high.

The block drives five outputs:
- byte offsets for two 16 KB program windows (CPU 0x8000 and 0xC000);
- byte offsets for two 4 KB pattern windows;
- a 2-bit mirroring code.

A window offset is recomputed only when the register that feeds it is written. A later change of mode in the control register does not move windows that are already mapped. The bank counts are parameters, and every bank number is reduced modulo the count of banks of the relevant size.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset the outputs are as follows: program low window at offset 0, program high window at the last 16 KB bank, pattern windows at offsets 0x0000 and 0x1000, and mirror code 0. The control register starts at 0x0C, so the program layout starts in mode 3.
- R2: A qualified write with data bit 7 set has these effects:
  - it discards any partial load, so five further writes are needed to complete one;
  - it sets control bits 3:2 to 3 and keeps the other control bits;
  - it changes no window offset and no mirror code.
- R3: Qualified writes without bit 7 shift data bit 0 in, first bit received being value bit 0. The fifth such write completes the load. Its address bits 14:13 pick the target: 0 is control, 1 is pattern bank 0, 2 is pattern bank 1 and 3 is program bank. The addresses of the first four writes do not matter.
- R4: `mirror` equals control bits 1:0. The codes are 0 for single lower, 1 for single upper, 2 for vertical and 3 for horizontal.
- R5: With control bit 4 = 0, writing pattern bank 0 with value v maps both pattern windows as one 8 KB unit. The low window goes to ((v>>1) mod CHR_BANKS8)·8 KB and the high window to that offset + 4 KB. A write to pattern bank 1 changes nothing in this mode.
- R6: With control bit 4 = 1, pattern bank 0 sets only the low window and pattern bank 1 sets only the high window. Each goes to (v mod 2·CHR_BANKS8)·4 KB.
- R7: With control bits 3:2 equal to 0 or 1, a program write maps a 32 KB unit. The low window goes to ((v[3:0]>>1) mod (PRG_BANKS16/2))·32 KB and the high window to that offset + 16 KB.
- R8: With control bits 3:2 = 2, a program write keeps the low window at 0 and sets the high window to (v[3:0] mod PRG_BANKS16)·16 KB.
- R9: With control bits 3:2 = 3, a program write sets the low window to (v[3:0] mod PRG_BANKS16)·16 KB and the high window to the last 16 KB bank.
- R10: Bank values beyond the available count wrap modulo the bank count. Program values use only bits 3:0.
- R11: The following have no effect on any state or output:
  - cycles with `wr_en` low;
  - writes with address bit 15 clear;
  - a control write, which does not remap existing windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| prg_lo_base | output | PRG_AW | Byte offset of the 16 KB window at 0x8000 |
| prg_hi_base | output | PRG_AW | Byte offset of the 16 KB window at 0xC000 |
| chr_lo_base | output | CHR_AW | Byte offset of the lower 4 KB pattern window |
| chr_hi_base | output | CHR_AW | Byte offset of the upper 4 KB pattern window |
| mirror | output | 2 | Mirroring code |

## Verification
Every program-layout mode is exercised with at least two values:
- one value inside the bank range;
- one value whose upper bits must wrap or be dropped.

This separates a missing LSB mask from a missing modulo. Pattern banking is tried in both widths, including a write to the second register in 8 KB mode, which must do nothing.

Serial framing is exercised in three ways:
- ignored writes are interleaved inside a load;
- the first four bits are sent to a different target address than the fifth;
- a load is aborted by bit 7 after three bits.

Each of these is checked both before and on the completing write, so an early or late commit shows up.

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl #(
  parameter int PRG_BANKS16 = 8,
  parameter int CHR_BANKS8  = 4,
  localparam int PRG_AW = $clog2(PRG_BANKS16) + 14,
  localparam int CHR_AW = $clog2(CHR_BANKS8) + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       addr,
  input  logic [7:0]        wdata,
  output logic [PRG_AW-1:0] prg_lo_base,
  output logic [PRG_AW-1:0] prg_hi_base,
  output logic [CHR_AW-1:0] chr_lo_base,
  output logic [CHR_AW-1:0] chr_hi_base,
  output logic [1:0]        mirror
);

  localparam logic [4:0] SHIFT_INIT = 5'h10;
  localparam logic [4:0] CTL_INIT   = 5'h0C;

  function automatic logic [PRG_AW-1:0] prg16(input logic [3:0] v);
    int unsigned b;
    b = (int'(v) % PRG_BANKS16) << 14;
    return PRG_AW'(b);
  endfunction

  function automatic logic [PRG_AW-1:0] prg32(input logic [3:0] v);
    int unsigned b;
    b = ((int'(v) >> 1) % (PRG_BANKS16 / 2)) << 15;
    return PRG_AW'(b);
  endfunction

  function automatic logic [CHR_AW-1:0] chr4(input logic [4:0] v);
    int unsigned b;
    b = (int'(v) % (2 * CHR_BANKS8)) << 12;
    return CHR_AW'(b);
  endfunction

  function automatic logic [CHR_AW-1:0] chr8(input logic [4:0] v, input logic upper);
    int unsigned b;
    b = (((int'(v) >> 1) % CHR_BANKS8) << 13) | (upper ? 32'h1000 : 32'h0);
    return CHR_AW'(b);
  endfunction

  localparam logic [PRG_AW-1:0] PRG_LAST = PRG_AW'((PRG_BANKS16 - 1) << 14);

  logic [4:0] shift_q;
  logic [4:0] ctl_q;

  wire       hit      = wr_en & addr[15];
  wire       esc      = hit & wdata[7];
  wire [4:0] shift_nx = {wdata[0], shift_q[4:1]};
  wire       done     = hit & ~wdata[7] & shift_q[0];
  wire [1:0] target   = addr[14:13];

  assign mirror = ctl_q[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q     <= SHIFT_INIT;
      ctl_q       <= CTL_INIT;
      prg_lo_base <= '0;
      prg_hi_base <= PRG_LAST;
      chr_lo_base <= '0;
      chr_hi_base <= CHR_AW'(32'h1000);
    end else if (esc) begin
      shift_q <= SHIFT_INIT;
      ctl_q   <= ctl_q | CTL_INIT;
    end else if (hit && !shift_q[0]) begin
      shift_q <= shift_nx;
    end else if (done) begin
      shift_q <= SHIFT_INIT;
      case (target)
        2'd0: ctl_q <= shift_nx;
        2'd1: begin
          if (ctl_q[4]) begin
            chr_lo_base <= chr4(shift_nx);
          end else begin
            chr_lo_base <= chr8(shift_nx, 1'b0);
            chr_hi_base <= chr8(shift_nx, 1'b1);
          end
        end
        2'd2: if (ctl_q[4]) chr_hi_base <= chr4(shift_nx);
        default: begin
          case (ctl_q[3:2])
            2'd2: begin
              prg_lo_base <= '0;
              prg_hi_base <= prg16(shift_nx[3:0]);
            end
            2'd3: begin
              prg_lo_base <= prg16(shift_nx[3:0]);
              prg_hi_base <= PRG_LAST;
            end
            default: begin
              prg_lo_base <= prg32(shift_nx[3:0]);
              prg_hi_base <= prg32(shift_nx[3:0]) | PRG_AW'(32'h4000);
            end
          endcase
        end
      endcase
    end
  end

  AST_ESC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    esc |=> shift_q == SHIFT_INIT); // R2
  AST_ESC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    esc |=> ctl_q[3:2] == 2'b11 && mirror == $past(mirror)); // R2
  AST_ESC_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
    esc |=> $stable(prg_lo_base) && $stable(prg_hi_base)); // R2
  AST_COMMIT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> shift_q == SHIFT_INIT); // R3
  AST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(shift_q) && $stable(ctl_q) && $stable(prg_lo_base)
             && $stable(prg_hi_base) && $stable(chr_lo_base) && $stable(chr_hi_base)); // R11
  AST_FIXED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && target == 2'd3 && ctl_q[3:2] == 2'd3) |=> prg_hi_base == PRG_LAST); // R9
  AST_FIXED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && target == 2'd3 && ctl_q[3:2] == 2'd2) |=> prg_lo_base == '0); // R8
  AST_CHR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && target == 2'd1 && !ctl_q[4]) |=> chr_hi_base == (chr_lo_base | CHR_AW'(32'h1000))); // R5

endmodule

// File: tb/sim_serial_bank_ctrl.sv
module sim_serial_bank_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0;
  logic [16:0] prg_lo_base, prg_hi_base;
  logic [14:0] chr_lo_base, chr_hi_base;
  logic [1:0]  mirror;
  int checks = 0, fails = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  serial_bank_ctrl #(.PRG_BANKS16(8), .CHR_BANKS8(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .prg_lo_base(prg_lo_base), .prg_hi_base(prg_hi_base),
    .chr_lo_base(chr_lo_base), .chr_hi_base(chr_hi_base), .mirror(mirror));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr1(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic write5(input logic [15:0] a, input logic [4:0] v);
    for (int i = 0; i < 5; i++) wr1(a, {7'b0, v[i]});
  endtask

  task automatic t_reset;
    chk("R1 prg_lo", prg_lo_base, 0);
    chk("R1 prg_hi", prg_hi_base, 32'h1C000);
    chk("R1 chr_lo", chr_lo_base, 0);
    chk("R1 chr_hi", chr_hi_base, 32'h1000);
    chk("R1 mirror", mirror, 0);
  endtask

  task automatic t_prg_mode3;
    write5(16'hE000, 5'd5);
    chk("R9 lo", prg_lo_base, 32'h14000);
    chk("R9 hi", prg_hi_base, 32'h1C000);
    write5(16'hE000, 5'h1E);
    chk("R10 lo wrap", prg_lo_base, 32'h18000);
    chk("R9 hi fixed", prg_hi_base, 32'h1C000);
  endtask

  task automatic t_mirror;
    write5(16'h8000, 5'h0E); chk("R4 vertical", mirror, 2);
    write5(16'h8000, 5'h0F); chk("R4 horizontal", mirror, 3);
    write5(16'h8000, 5'h0D); chk("R4 upper", mirror, 1);
    chk("R11 ctl no remap", prg_lo_base, 32'h18000);
  endtask

  task automatic t_prg_mode2;
    write5(16'h8000, 5'h08); chk("R4 lower", mirror, 0);
    write5(16'hE000, 5'd3);
    chk("R8 lo", prg_lo_base, 0);
    chk("R8 hi", prg_hi_base, 32'h0C000);
    write5(16'hE000, 5'h0C);
    chk("R10 mode2 wrap", prg_hi_base, 32'h10000);
  endtask

  task automatic t_prg_mode0;
    write5(16'h8000, 5'h00);
    write5(16'hE000, 5'd5);
    chk("R7 lo", prg_lo_base, 32'h10000);
    chk("R7 hi", prg_hi_base, 32'h14000);
    write5(16'hE000, 5'h0F);
    chk("R7 wrap lo", prg_lo_base, 32'h18000);
    chk("R7 wrap hi", prg_hi_base, 32'h1C000);
    write5(16'h8000, 5'h04);
    write5(16'hE000, 5'd2);
    chk("R7 mode1 lo", prg_lo_base, 32'h08000);
    chk("R7 mode1 hi", prg_hi_base, 32'h0C000);
  endtask

  task automatic t_chr8;
    write5(16'hA000, 5'd3);
    chk("R5 lo", chr_lo_base, 32'h2000);
    chk("R5 hi", chr_hi_base, 32'h3000);
    write5(16'hC000, 5'd6);
    chk("R5 bank1 ignored lo", chr_lo_base, 32'h2000);
    chk("R5 bank1 ignored hi", chr_hi_base, 32'h3000);
    write5(16'hA000, 5'h0D);
    chk("R5 wrap lo", chr_lo_base, 32'h4000);
    chk("R5 wrap hi", chr_hi_base, 32'h5000);
  endtask

  task automatic t_chr4;
    write5(16'h8000, 5'h10);
    write5(16'hA000, 5'd3);
    chk("R6 lo", chr_lo_base, 32'h3000);
    chk("R6 hi kept", chr_hi_base, 32'h5000);
    write5(16'hC000, 5'd9);
    chk("R6 hi", chr_hi_base, 32'h1000);
    write5(16'hC000, 5'h1F);
    chk("R10 chr wrap", chr_hi_base, 32'h7000);
    chk("R6 lo kept", chr_lo_base, 32'h3000);
  endtask

  task automatic t_ignore;
    wr1(16'hE000, 8'h00);
    wr1(16'hE000, 8'h01);
    wr1(16'h6000, 8'hFF);
    wr1(16'h0000, 8'h01);
    @(negedge clk); addr = 16'hE000; wdata = 8'h80;
    @(negedge clk);
    chk("R11 ignored", prg_lo_base, 32'h08000);
    chk("R11 mirror kept", mirror, 0);
    wr1(16'hE000, 8'h01);
    wr1(16'hE000, 8'h00);
    chk("R3 no early commit", prg_lo_base, 32'h08000);
    wr1(16'hE000, 8'h00);
    chk("R3 commit on fifth", prg_lo_base, 32'h18000);
    chk("R3 hi", prg_hi_base, 32'h1C000);
  endtask

  task automatic t_target;
    for (int i = 0; i < 4; i++) wr1(16'h8000, {7'b0, i == 0 || i == 2});
    wr1(16'hA000, 8'h00);
    chk("R3 last addr picks", chr_lo_base, 32'h5000);
    chk("R3 ctl untouched", mirror, 0);
  endtask

  task automatic t_escape;
    write5(16'h8000, 5'h12);
    chk("R4 vertical again", mirror, 2);
    for (int i = 0; i < 3; i++) wr1(16'hE000, 8'h01);
    wr1(16'hE000, 8'h80);
    chk("R2 mirror kept", mirror, 2);
    chk("R2 prg lo kept", prg_lo_base, 32'h18000);
    chk("R2 prg hi kept", prg_hi_base, 32'h1C000);
    wr1(16'hE000, 8'h00);
    wr1(16'hE000, 8'h01);
    wr1(16'hE000, 8'h00);
    wr1(16'hE000, 8'h00);
    chk("R2 needs five", prg_lo_base, 32'h18000);
    wr1(16'hE000, 8'h00);
    chk("R2 mode3 lo", prg_lo_base, 32'h08000);
    chk("R2 mode3 hi", prg_hi_base, 32'h1C000);
    write5(16'hC000, 5'd2);
    chk("R2 chr4 kept", chr_hi_base, 32'h2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prg_mode3();
    t_mirror();
    t_prg_mode2();
    t_prg_mode0();
    t_chr8();
    t_chr4();
    t_ignore();
    t_target();
    t_escape();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule